// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block prepares an asynchronous DRAM for use and then keeps its contents alive. Once reset is released, it holds off all strobe activity for a settling pause. It then drives a burst of dummy refresh cycles to wake up the array, and only after those cycles does it declare the memory usable. From that point on, an interval timer spaces refresh cycles so that every row is visited once per retention period.

Refresh shares the DRAM with a normal-access controller through a request/grant handshake. The scheduler raises `bus_req` whenever at least one refresh is owed. It starts a refresh cycle only when it sees `bus_gnt` high at a clock edge. It keeps `bus_req` high until the RAS precharge of its last owed cycle has finished, and the arbiter holds the grant for as long as the request stays high. If the grant is late, the owed refreshes pile up in a saturating counter and are paid back in a single burst.

A build parameter selects one of two refresh styles. In the CAS-first style, CAS falls before RAS and no address is needed. In the row-addressed style, CAS stays high and the block supplies a row address that advances after every cycle. All durations are written in nanoseconds or as clock counts, and the block converts them using the clock period parameter.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, `ready` and `bus_req` are low and `ras_n` and `cas_n` are high.
- R2: The first strobe edge after reset release happens exactly PAUSE_CLKS cycles after release. PAUSE_CLKS is the pause time divided by the clock period, rounded up.
- R3: Before `ready` rises, exactly INIT_CYCLES refresh cycles (default 8) are issued without any grant. `ready` rises RAS_PRE_CLKS cycles after RAS rises for the last of them, and `bus_req` stays low as long as `ready` is low.
- R4: Once `ready` is high, it stays high until the next reset.
- R5: After `ready`, a refresh cycle starts only on an edge where `bus_gnt` is sampled high. With the grant held high, successive refresh cycles start exactly INTERVAL_CLKS cycles apart. INTERVAL_CLKS is the refresh period divided by (rows × clock period), rounded down.
- R6: Each timer expiry that is not yet served adds one to an owed count, which saturates at MAX_PEND (default 8). When the grant arrives, exactly that many refresh cycles run back to back.
- R7: `bus_req` is high whenever a refresh is owed or a refresh cycle is under way. It falls exactly RAS_PRE_CLKS cycles after RAS rises for the final owed cycle.
- R8: Every refresh cycle holds `ras_n` low for exactly RAS_LOW_CLKS cycles.
- R9: In CAS-first mode (CBR_MODE=1), `cas_n` falls exactly CAS_SETUP_CLKS cycles before `ras_n` falls, and both strobes rise on the same edge.
- R10: In row-addressed mode (CBR_MODE=0), `cas_n` never goes low and `row_addr` is stable while `ras_n` is low. The row presented at successive refreshes counts up by one from 0 and wraps to 0 after 2**ROW_BITS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt | input | 1 | Arbiter grant, held while `bus_req` is high |
| bus_req | output | 1 | Refresh owed or refresh cycle in progress |
| ready | output | 1 | Power-up sequence complete; DRAM usable |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low (CAS-first mode only) |
| row_addr | output | ROW_BITS | Row to refresh in row-addressed mode |

## Verification
The bench uses a 10 ns clock, a 2 µs pause (200 cycles) and 16 rows over a 32 µs period. That puts the refresh interval at 200 cycles, so power-up, several intervals and row wrap all complete within a few thousand cycles. The strobe timings are set to a 2-cycle CAS setup, 4 cycles of RAS low and 3 cycles of precharge. One nine-cycle refresh is therefore much shorter than an interval, and the bench can place the grant release at a known distance from a timer expiry. This lets it count a burst of owed refreshes exactly, whether the count is below the saturation limit or held at it. Two instances run side by side. One is CAS-first, with its grant driven by the test tasks. The other is row-addressed, with its grant tied to its own request, so that row wrap is reached within the run.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    // Top-level sequencing mode of the scheduler
    typedef enum logic [1:0] {
        MD_PAUSE = 2'd0,
        MD_INIT  = 2'd1,
        MD_RUN   = 2'd2
    } sched_mode_e;

    // Phase within one refresh cycle
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW   = 2'd2,
        PH_PRE   = 2'd3
    } rfsh_phase_e;

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int unsigned PERIOD_CLKS = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned TW = $clog2(PERIOD_CLKS + 1);

    logic [TW-1:0] cnt_d, cnt_q;
    logic          wrap;

    always_comb begin
        wrap  = en && (cnt_q == TW'(PERIOD_CLKS - 1));
        cnt_d = cnt_q;
        if (!en)       cnt_d = '0;
        else if (wrap) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
        tick  = wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rfsh_pending_ctr.sv
module rfsh_pending_ctr #(
    parameter int unsigned MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic owed
);
    localparam int unsigned PW = $clog2(MAX_PEND + 1);

    logic [PW-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        unique case ({inc, dec})
            2'b10:   if (pend_q != PW'(MAX_PEND)) pend_d = pend_q + 1'b1;
            2'b01:   if (pend_q != '0)            pend_d = pend_q - 1'b1;
            default: pend_d = pend_q;
        endcase
        owed = (pend_q != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/rfsh_cycle_seq.sv
module rfsh_cycle_seq
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CLKS     = 20000,
    parameter int unsigned INIT_CYCLES    = 8,
    parameter int unsigned RAS_LOW_CLKS   = 6,
    parameter int unsigned RAS_PRE_CLKS   = 5,
    parameter int unsigned CAS_SETUP_CLKS = 2,
    parameter int unsigned ROW_BITS       = 12,
    parameter bit          CBR_MODE       = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                owed,
    input  logic                gnt,
    output logic                ready,
    output logic                run_done,
    output logic                ras_n,
    output logic                cas_n,
    output logic [ROW_BITS-1:0] row_addr
);
    localparam int unsigned M1   = (RAS_LOW_CLKS > RAS_PRE_CLKS) ? RAS_LOW_CLKS : RAS_PRE_CLKS;
    localparam int unsigned M2   = (M1 > CAS_SETUP_CLKS) ? M1 : CAS_SETUP_CLKS;
    localparam int unsigned MAXC = (M2 > PAUSE_CLKS) ? M2 : PAUSE_CLKS;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam int unsigned IW   = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        sched_mode_e         mode;
        rfsh_phase_e         phase;
        logic [CW-1:0]       cnt;
        logic [IW-1:0]       inits;
        logic [ROW_BITS-1:0] row;
    } seq_t;

    seq_t s_d, s_q;
    logic done_d;

    always_comb begin
        s_d    = s_q;
        done_d = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (s_q.mode == MD_PAUSE) begin
                    if (s_q.cnt == CW'(PAUSE_CLKS - 1)) begin
                        s_d.mode  = MD_INIT;
                        s_d.phase = PH_SETUP;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end else if (s_q.mode == MD_RUN && owed && gnt) begin
                    s_d.phase = PH_SETUP;
                    s_d.cnt   = '0;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == CW'(CAS_SETUP_CLKS - 1)) begin
                    s_d.phase = PH_LOW;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_LOW: begin
                if (s_q.cnt == CW'(RAS_LOW_CLKS - 1)) begin
                    s_d.phase = PH_PRE;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_PRE: begin
                if (s_q.cnt == CW'(RAS_PRE_CLKS - 1)) begin
                    s_d.cnt   = '0;
                    s_d.row   = s_q.row + 1'b1;
                    s_d.phase = PH_IDLE;
                    if (s_q.mode == MD_INIT) begin
                        if (s_q.inits == IW'(INIT_CYCLES - 1)) begin
                            s_d.mode = MD_RUN;
                        end else begin
                            s_d.inits = s_q.inits + 1'b1;
                            s_d.phase = PH_SETUP;
                        end
                    end else begin
                        done_d = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready    = (s_q.mode == MD_RUN);
    assign run_done = done_d;
    assign ras_n    = (s_q.phase != PH_LOW);
    assign row_addr = s_q.row;

    generate
        if (CBR_MODE) begin : g_cas_first
            assign cas_n = !((s_q.phase == PH_SETUP) || (s_q.phase == PH_LOW));
        end else begin : g_row_addr
            assign cas_n = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int unsigned CLK_PERIOD_NS     = 10,
    parameter int unsigned PAUSE_NS          = 200000,
    parameter int unsigned REFRESH_PERIOD_NS = 64000000,
    parameter int unsigned ROW_BITS          = 12,
    parameter int unsigned INIT_CYCLES       = 8,
    parameter int unsigned MAX_PEND          = 8,
    parameter int unsigned RAS_LOW_CLKS      = 6,
    parameter int unsigned RAS_PRE_CLKS      = 5,
    parameter int unsigned CAS_SETUP_CLKS    = 2,
    parameter bit          CBR_MODE          = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_gnt,
    output logic                bus_req,
    output logic                ready,
    output logic                ras_n,
    output logic                cas_n,
    output logic [ROW_BITS-1:0] row_addr
);
    localparam int unsigned PAUSE_CLKS    = (PAUSE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int unsigned INTERVAL_CLKS = REFRESH_PERIOD_NS / (CLK_PERIOD_NS * (2 ** ROW_BITS));

    logic tick;
    logic owed;
    logic run_done;

    rfsh_interval_timer #(
        .PERIOD_CLKS (INTERVAL_CLKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ready),
        .tick  (tick)
    );

    rfsh_pending_ctr #(
        .MAX_PEND (MAX_PEND)
    ) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (run_done),
        .owed  (owed)
    );

    rfsh_cycle_seq #(
        .PAUSE_CLKS     (PAUSE_CLKS),
        .INIT_CYCLES    (INIT_CYCLES),
        .RAS_LOW_CLKS   (RAS_LOW_CLKS),
        .RAS_PRE_CLKS   (RAS_PRE_CLKS),
        .CAS_SETUP_CLKS (CAS_SETUP_CLKS),
        .ROW_BITS       (ROW_BITS),
        .CBR_MODE       (CBR_MODE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .owed     (owed),
        .gnt      (bus_gnt),
        .ready    (ready),
        .run_done (run_done),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .row_addr (row_addr)
    );

    assign bus_req = ready && owed;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
    parameter int unsigned ROW_BITS = 12,
    parameter bit          CBR_MODE = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_gnt,
    input logic                bus_req,
    input logic                ready,
    input logic                ras_n,
    input logic                cas_n,
    input logic [ROW_BITS-1:0] row_addr
);
    p_no_req_before_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !bus_req);

    p_ready_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    p_req_covers_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && (!ras_n || !cas_n)) |-> bus_req);

    p_start_needs_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ras_n && cas_n && !bus_gnt && !bus_req) |=> (ras_n && cas_n));

    p_cas_at_ras_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (cas_n == !CBR_MODE));

    p_strobes_rise_together_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> cas_n);

    p_row_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |=> (ras_n || $stable(row_addr)));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
    .ROW_BITS (ROW_BITS),
    .CBR_MODE (CBR_MODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_gnt  (bus_gnt),
    .bus_req  (bus_req),
    .ready    (ready),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .row_addr (row_addr)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
    localparam int CLK_NS   = 10;
    localparam int PAUSE    = 200;   // 2000 ns / 10 ns
    localparam int INTERVAL = 200;   // 32000 ns / (16 rows * 10 ns)
    localparam int SETUP    = 2;
    localparam int LOWW     = 4;
    localparam int PRE      = 3;
    localparam int NINIT    = 8;
    localparam int PMAX     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt_a = 1'b0;
    logic req_a, rdy_a, ras_a, cas_a;
    logic [3:0] row_a;
    logic req_b, rdy_b, ras_b, cas_b;
    logic [3:0] row_b;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_NS/2) clk = ~clk;

    dram_refresh_sched #(
        .CLK_PERIOD_NS(CLK_NS), .PAUSE_NS(2000), .REFRESH_PERIOD_NS(32000),
        .ROW_BITS(4), .INIT_CYCLES(NINIT), .MAX_PEND(PMAX),
        .RAS_LOW_CLKS(LOWW), .RAS_PRE_CLKS(PRE), .CAS_SETUP_CLKS(SETUP), .CBR_MODE(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_gnt(gnt_a), .bus_req(req_a),
        .ready(rdy_a), .ras_n(ras_a), .cas_n(cas_a), .row_addr(row_a)
    );

    dram_refresh_sched #(
        .CLK_PERIOD_NS(CLK_NS), .PAUSE_NS(2000), .REFRESH_PERIOD_NS(32000),
        .ROW_BITS(4), .INIT_CYCLES(NINIT), .MAX_PEND(PMAX),
        .RAS_LOW_CLKS(LOWW), .RAS_PRE_CLKS(PRE), .CAS_SETUP_CLKS(SETUP), .CBR_MODE(1'b0)
    ) u_dut_row (
        .clk(clk), .rst_n(rst_n), .bus_gnt(req_b), .bus_req(req_b),
        .ready(rdy_b), .ras_n(ras_b), .cas_n(cas_b), .row_addr(row_b)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Monitor state, sampled at the falling edge
    int  falls_a = 0, last_fall_a = 0, prev_fall_a = 0, last_rise_a = 0, cas_fall_a = 0;
    bit  seen_a = 1'b0;
    int  falls_b = 0, last_fall_b = 0;
    logic [3:0] row_at_fall_b = '0;
    logic p_ras_a = 1'b1, p_cas_a = 1'b1, p_rdy_a = 1'b0, p_req_a = 1'b0, p_gnt_a = 1'b0;
    logic p_ras_b = 1'b1, p_rdy_b = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            // CAS-first instance
            if (p_cas_a && !cas_a) begin
                if (!seen_a) check(cyc == PAUSE, "R2", cyc, PAUSE);
                seen_a = 1'b1;
                if (rdy_a) check(p_gnt_a == 1'b1, "R5", p_gnt_a, 1);
                cas_fall_a = cyc;
            end
            if (p_ras_a && !ras_a) begin
                check(cyc - cas_fall_a == SETUP, "R9", cyc - cas_fall_a, SETUP);
                falls_a++;
                prev_fall_a = last_fall_a;
                last_fall_a = cyc;
            end
            if (!p_ras_a && ras_a) begin
                check(cyc - last_fall_a == LOWW, "R8", cyc - last_fall_a, LOWW);
                check(cas_a == 1'b1, "R9", cas_a, 1);
                last_rise_a = cyc;
            end
            if (!p_rdy_a && rdy_a) begin
                check(falls_a == NINIT, "R3", falls_a, NINIT);
                check(cyc - last_rise_a == PRE, "R3", cyc - last_rise_a, PRE);
            end
            if (p_rdy_a && !rdy_a) check(1'b0, "R4", 0, 1);
            if (!rdy_a && req_a)   check(1'b0, "R3", 1, 0);
            if (rdy_a && (!ras_a || !cas_a) && !req_a) check(1'b0, "R7", 0, 1);
            if (p_req_a && !req_a)
                check(cyc - last_rise_a == PRE, "R7", cyc - last_rise_a, PRE);
            // Row-addressed instance
            if (!cas_b) check(1'b0, "R10", 0, 1);
            if (p_ras_b && !ras_b) begin
                if (falls_b == 0) check(cyc == PAUSE + SETUP, "R2", cyc, PAUSE + SETUP);
                check(int'(row_b) == (falls_b % 16), "R10", row_b, falls_b % 16);
                row_at_fall_b = row_b;
                falls_b++;
                last_fall_b = cyc;
            end
            if (!p_ras_b && ras_b) begin
                check(cyc - last_fall_b == LOWW, "R8", cyc - last_fall_b, LOWW);
                check(row_b == row_at_fall_b, "R10", row_b, row_at_fall_b);
            end
            if (p_rdy_b && !rdy_b) check(1'b0, "R4", 0, 1);
        end
        p_ras_a = ras_a; p_cas_a = cas_a; p_rdy_a = rdy_a; p_req_a = req_a; p_gnt_a = gnt_a;
        p_ras_b = ras_b; p_rdy_b = rdy_b;
    end

    task automatic t_reset();
        rst_n = 1'b0;
        gnt_a = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(rdy_a == 1'b0 && rdy_b == 1'b0, "R1", rdy_a, 0);
        check(req_a == 1'b0 && req_b == 1'b0, "R1", req_a, 0);
        check(ras_a && cas_a && ras_b && cas_b, "R1", {ras_a, cas_a}, 3);
        @(posedge clk); #2;
        rst_n = 1'b1;
    endtask

    task automatic t_power_up();
        while (!(rdy_a && rdy_b)) @(negedge clk);
        check(falls_a == NINIT, "R3", falls_a, NINIT);
        check(falls_b == NINIT, "R3", falls_b, NINIT);
    endtask

    task automatic t_steady_interval();
        int f0;
        @(posedge clk); #2;
        gnt_a = 1'b1;
        f0 = falls_a;
        while (falls_a < f0 + 3) @(negedge clk);
        check(last_fall_a - prev_fall_a == INTERVAL, "R5", last_fall_a - prev_fall_a, INTERVAL);
    endtask

    task automatic t_deferred(input int n);
        int x, f0, exp;
        @(negedge clk);
        while (req_a) @(negedge clk);
        @(posedge clk); #2;
        gnt_a = 1'b0;
        @(negedge clk);
        while (!req_a) @(negedge clk);
        x = cyc;
        f0 = falls_a;
        while (cyc < x + (n - 1) * INTERVAL + 5) @(negedge clk);
        check(falls_a == f0, "R5", falls_a - f0, 0);
        check(req_a == 1'b1, "R7", req_a, 1);
        @(posedge clk); #2;
        gnt_a = 1'b1;
        @(negedge clk);
        while (req_a) @(negedge clk);
        exp = (n > PMAX) ? PMAX : n;
        check(falls_a - f0 == exp, "R6", falls_a - f0, exp);
    endtask

    task automatic t_row_wrap();
        while (falls_b < 20) @(negedge clk);
        check(falls_b >= 20, "R10", falls_b, 20);
        check(rdy_a && rdy_b, "R4", rdy_a, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        summary();
    end

    initial begin
        t_reset();
        t_power_up();
        t_steady_interval();
        t_deferred(3);
        t_deferred(20);
        t_row_wrap();
        repeat (5) @(posedge clk);
        summary();
    end
endmodule